// File: doc/BRIEF.md
# Repeating Block Output Transfer Sequencer

This block copies a run of bytes from memory to a single I/O port, walking the memory pointer downwards one byte at a time. Software loads a 16-bit memory pointer, an 8-bit transfer counter and an 8-bit port number with a single start pulse. The sequencer then runs one pass per byte. Each pass reads the byte at the pointer and decrements the counter. It then writes the byte to the port, with the new counter value on the upper half of the I/O address. Finally it steps the pointer down.

Each pass follows a fixed clock budget built from consecutive phases. A pass that is followed by another one lasts 21 clocks, in phases of 4, 5, 3, 4 and 5 clocks. The final pass drops the closing phase and lasts 16 clocks. A repeat-point pulse marks the end of every pass, so that surrounding logic can take an interrupt between transfers. When the counter reaches zero the sequencer stops and raises done. The final pointer and counter values stay visible on the outputs until the next start.

Top module: `blkout_seq`

## Requirements
- R1: After reset, busy, done, mem_rd, io_wr and rpt_pulse are all low. A start pulse while idle loads ptr_out, cnt_out and the port number from ld_ptr, ld_cnt and ld_port, raises busy on the next clock and clears done.
- R2: In every pass, mem_rd is high for exactly one clock, the 10th clock of the pass (offset 9 from the pass start), with mem_addr equal to the current pointer. The memory returns data one clock later and holds it.
- R3: The counter is decremented once per pass, at the end of the pass's 12th clock, which is before the I/O write. io_addr carries the port number on bits 7:0 and the decremented counter on bits 15:8.
- R4: io_wr is high for exactly one clock per pass, the 16th clock of the pass (offset 15). io_wdata is then the byte read in that pass, and io_addr and io_wdata are stable across the clock before it.
- R5: After each write, the pointer is decremented by one, and it wraps from 0x0000 to 0xFFFF.
- R6: A pass is repeated while the decremented counter is nonzero. A start counter of N in 1..255 gives N transfers, and a start counter of 0 gives 256 transfers.
- R7: A repeating pass lasts 21 clocks and the final pass lasts 16 clocks, so busy stays high for 21*(N-1)+16 clocks.
- R8: rpt_pulse is high for one clock on the last clock of every pass: offset 20 of a repeating pass, and the last busy clock of the final pass.
- R9: When the final pass ends, busy falls and done rises. ptr_out and cnt_out then hold their final values, with cnt_out equal to 0, until the next accepted start, which clears done.
- R10: A start pulse while busy is ignored. The running copy and its timing are unaffected, and so are the loaded pointer, counter and port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load-and-run request, honoured only while idle |
| ld_ptr | input | 16 | Initial memory pointer |
| ld_cnt | input | 8 | Initial transfer counter (0 means 256) |
| ld_port | input | 8 | Port number for the low I/O address byte |
| mem_addr | output | 16 | Memory read address (current pointer) |
| mem_rd | output | 1 | Memory read strobe, one clock |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_rd |
| io_addr | output | 16 | I/O address {counter, port} |
| io_wdata | output | 8 | Byte being written to the port |
| io_wr | output | 1 | I/O write strobe, one clock |
| rpt_pulse | output | 1 | End-of-pass marker |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Copy finished |
| ptr_out | output | 16 | Current memory pointer |
| cnt_out | output | 8 | Current counter |

## Verification
The properties assume that ld_ptr, ld_cnt and ld_port are valid in the clock where an idle start is sampled. They also assume that the memory presents read data in the clock after mem_rd and keeps it there until the next read. The bench memory is a registered model that updates only on mem_rd and computes each byte from its address, so the second assumption always holds. The bench drives every load value together with start on the falling edge. When it sends a start while the copy is running, it changes the load values too, so that a wrongly accepted load would show up on the outputs.

// File: rtl/blkout_pkg.sv
package blkout_pkg;
    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_MEMRD  = 3'd2,
        PH_IOWR   = 3'd3,
        PH_TAIL   = 3'd4
    } phase_e;

    function automatic int unsigned max5(int unsigned a, int unsigned b, int unsigned c,
                                         int unsigned d, int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction
endpackage

// File: rtl/blkout_phase_timer.sv
module blkout_phase_timer
    import blkout_pkg::*;
#(
    parameter int unsigned LEN_FETCH  = 4,
    parameter int unsigned LEN_DECODE = 5,
    parameter int unsigned LEN_MEMRD  = 3,
    parameter int unsigned LEN_IOWR   = 4,
    parameter int unsigned LEN_TAIL   = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   skip_tail,
    output phase_e phase,
    output logic   tick_first,
    output logic   phase_last,
    output logic   pass_end
);
    localparam int unsigned MAXLEN = max5(LEN_FETCH, LEN_DECODE, LEN_MEMRD, LEN_IOWR, LEN_TAIL);
    localparam int unsigned TKW    = $clog2(MAXLEN + 1);

    typedef struct packed {
        phase_e         ph;
        logic [TKW-1:0] tk;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [TKW-1:0] len_m1;

    always_comb begin
        case (s_q.ph)
            PH_FETCH:  len_m1 = TKW'(LEN_FETCH - 1);
            PH_DECODE: len_m1 = TKW'(LEN_DECODE - 1);
            PH_MEMRD:  len_m1 = TKW'(LEN_MEMRD - 1);
            PH_IOWR:   len_m1 = TKW'(LEN_IOWR - 1);
            PH_TAIL:   len_m1 = TKW'(LEN_TAIL - 1);
            default:   len_m1 = '0;
        endcase
    end

    assign phase      = s_q.ph;
    assign tick_first = run && (s_q.tk == '0);
    assign phase_last = run && (s_q.tk == len_m1);
    assign pass_end   = phase_last && ((s_q.ph == PH_TAIL) || ((s_q.ph == PH_IOWR) && skip_tail));

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.ph = PH_FETCH;
            s_d.tk = '0;
        end else if (phase_last) begin
            s_d.tk = '0;
            if (pass_end) begin
                s_d.ph = PH_FETCH;
            end else begin
                case (s_q.ph)
                    PH_FETCH:  s_d.ph = PH_DECODE;
                    PH_DECODE: s_d.ph = PH_MEMRD;
                    PH_MEMRD:  s_d.ph = PH_IOWR;
                    PH_IOWR:   s_d.ph = PH_TAIL;
                    default:   s_d.ph = PH_FETCH;
                endcase
            end
        end else begin
            s_d.tk = s_q.tk + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph <= PH_FETCH;
            s_q.tk <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/blkout_regs.sv
module blkout_regs #(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 8,
    parameter int unsigned PW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_ptr,
    input  logic [CW-1:0] ld_cnt,
    input  logic [PW-1:0] ld_port,
    input  logic          capture,
    input  logic [DW-1:0] rdata,
    input  logic          dec_cnt,
    input  logic          dec_ptr,
    output logic [AW-1:0] ptr,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] port,
    output logic [DW-1:0] hold
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic [PW-1:0] port;
        logic [DW-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.ptr  = ld_ptr;
            r_d.cnt  = ld_cnt;
            r_d.port = ld_port;
        end else begin
            if (capture) r_d.hold = rdata;
            if (dec_cnt) r_d.cnt  = r_q.cnt - 1'b1;
            if (dec_ptr) r_d.ptr  = r_q.ptr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ptr  = r_q.ptr;
    assign cnt  = r_q.cnt;
    assign port = r_q.port;
    assign hold = r_q.hold;
endmodule

// File: rtl/blkout_seq.sv
module blkout_seq
    import blkout_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned CW         = 8,
    parameter int unsigned PW         = 8,
    parameter int unsigned DW         = 8,
    parameter int unsigned LEN_FETCH  = 4,
    parameter int unsigned LEN_DECODE = 5,
    parameter int unsigned LEN_MEMRD  = 3,
    parameter int unsigned LEN_IOWR   = 4,
    parameter int unsigned LEN_TAIL   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    ld_ptr,
    input  logic [CW-1:0]    ld_cnt,
    input  logic [PW-1:0]    ld_port,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    input  logic [DW-1:0]    mem_rdata,
    output logic [CW+PW-1:0] io_addr,
    output logic [DW-1:0]    io_wdata,
    output logic             io_wr,
    output logic             rpt_pulse,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    ptr_out,
    output logic [CW-1:0]    cnt_out
);
    typedef struct packed {
        logic busy;
        logic done;
    } ctl_t;

    ctl_t   c_d, c_q;
    phase_e phase;
    logic   tick_first, phase_last, pass_end;
    logic   accept, cnt_zero, capture, dec_ptr;
    logic [AW-1:0] ptr;
    logic [CW-1:0] cnt;
    logic [PW-1:0] port;
    logic [DW-1:0] hold;

    assign accept   = start && !c_q.busy;
    assign cnt_zero = (cnt == '0);
    assign capture  = c_q.busy && (phase == PH_MEMRD) && phase_last;
    assign dec_ptr  = c_q.busy && (phase == PH_IOWR) && phase_last;

    blkout_phase_timer #(
        .LEN_FETCH (LEN_FETCH),
        .LEN_DECODE(LEN_DECODE),
        .LEN_MEMRD (LEN_MEMRD),
        .LEN_IOWR  (LEN_IOWR),
        .LEN_TAIL  (LEN_TAIL)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (c_q.busy),
        .skip_tail (cnt_zero),
        .phase     (phase),
        .tick_first(tick_first),
        .phase_last(phase_last),
        .pass_end  (pass_end)
    );

    blkout_regs #(
        .AW(AW), .CW(CW), .PW(PW), .DW(DW)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .ld_ptr (ld_ptr),
        .ld_cnt (ld_cnt),
        .ld_port(ld_port),
        .capture(capture),
        .rdata  (mem_rdata),
        .dec_cnt(capture),
        .dec_ptr(dec_ptr),
        .ptr    (ptr),
        .cnt    (cnt),
        .port   (port),
        .hold   (hold)
    );

    always_comb begin
        c_d = c_q;
        if (accept) begin
            c_d.busy = 1'b1;
            c_d.done = 1'b0;
        end else if (pass_end && cnt_zero) begin
            c_d.busy = 1'b0;
            c_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mem_addr  = ptr;
    assign mem_rd    = c_q.busy && (phase == PH_MEMRD) && tick_first;
    assign io_addr   = {cnt, port};
    assign io_wdata  = hold;
    assign io_wr     = dec_ptr;
    assign rpt_pulse = pass_end;
    assign busy      = c_q.busy;
    assign done      = c_q.done;
    assign ptr_out   = ptr;
    assign cnt_out   = cnt;
endmodule

// File: rtl/blkout_seq_chk.sv
module blkout_seq_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 8,
    parameter int unsigned PW = 8,
    parameter int unsigned DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [AW-1:0]    ld_ptr,
    input logic [CW-1:0]    ld_cnt,
    input logic             mem_rd,
    input logic [CW+PW-1:0] io_addr,
    input logic [DW-1:0]    io_wdata,
    input logic             io_wr,
    input logic             rpt_pulse,
    input logic             busy,
    input logic             done,
    input logic [AW-1:0]    ptr_out,
    input logic [CW-1:0]    cnt_out
);
    p_start_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && ptr_out == $past(ld_ptr) && cnt_out == $past(ld_cnt)));

    p_rd_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(cnt_out)) |-> (cnt_out == $past(cnt_out) - 1'b1));

    p_wr_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> !io_wr);

    p_wr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> ($stable(io_addr) && $stable(io_wdata)));

    p_ptr_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> (ptr_out == $past(ptr_out) - 1'b1));

    p_end_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && cnt_out == '0));

    p_rpt_one_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_pulse |=> !rpt_pulse);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(ptr_out) && $stable(cnt_out) && done));
endmodule

bind blkout_seq blkout_seq_chk #(.AW(AW), .CW(CW), .PW(PW), .DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ld_ptr   (ld_ptr),
    .ld_cnt   (ld_cnt),
    .mem_rd   (mem_rd),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .rpt_pulse(rpt_pulse),
    .busy     (busy),
    .done     (done),
    .ptr_out  (ptr_out),
    .cnt_out  (cnt_out)
);

// File: tb/test_blkout_seq.sv
module test_blkout_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ld_ptr = '0;
    logic [7:0]  ld_cnt = '0;
    logic [7:0]  ld_port = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr, rpt_pulse, busy, done;
    logic [15:0] ptr_out;
    logic [7:0]  cnt_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    blkout_seq i_blkout_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_ptr(ld_ptr), .ld_cnt(ld_cnt),
        .ld_port(ld_port), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .rpt_pulse(rpt_pulse),
        .busy(busy), .done(done), .ptr_out(ptr_out), .cnt_out(cnt_out)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

    // expected run parameters, written by tasks, read by monitor
    logic [15:0] e_ptr0;
    logic [7:0]  e_cnt0, e_port0;

    // monitor state
    logic        prev_busy = 1'b0;
    int          pos = 0, n_busy = 0, n_wr = 0, n_rd = 0, n_rpt = 0;
    int          n_err_wr = 0, n_err_rd = 0, n_err_rpt = 0;
    int          bad_act = 0, bad_exp = 0;
    logic [15:0] m_ptr;
    logic [7:0]  m_cnt;
    int          m_total;

    always @(negedge clk) begin
        if (busy) begin
            if (!prev_busy) begin
                pos = 0; n_busy = 0; n_wr = 0; n_rd = 0; n_rpt = 0;
                n_err_wr = 0; n_err_rd = 0; n_err_rpt = 0;
                m_ptr = e_ptr0; m_cnt = e_cnt0;
                m_total = 21 * (((e_cnt0 == 0) ? 256 : int'(e_cnt0)) - 1) + 16;
            end else begin
                pos = pos + 1;
            end
            n_busy = n_busy + 1;
            if (mem_rd) begin
                n_rd = n_rd + 1;
                if ((pos % 21) != 9 || mem_addr != m_ptr) begin
                    n_err_rd = n_err_rd + 1; bad_act = int'(mem_addr); bad_exp = int'(m_ptr);
                end
            end
            if (io_wr) begin
                n_wr = n_wr + 1;
                m_cnt = m_cnt - 8'd1;
                if ((pos % 21) != 15 || io_addr != {m_cnt, e_port0} || io_wdata != mem_byte(m_ptr)) begin
                    n_err_wr = n_err_wr + 1;
                    bad_act = int'({io_addr, io_wdata});
                    bad_exp = int'({m_cnt, e_port0, mem_byte(m_ptr)});
                end
                m_ptr = m_ptr - 16'd1;
            end
            if (rpt_pulse) begin
                n_rpt = n_rpt + 1;
                if (!((pos % 21) == 20 || pos == m_total - 1)) begin
                    n_err_rpt = n_err_rpt + 1; bad_act = pos; bad_exp = m_total - 1;
                end
            end
        end
        prev_busy = busy;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 7000 && busy; i++) @(negedge clk);
    endtask

    task automatic run_case(input logic [15:0] p, input logic [7:0] c, input logic [7:0] prt,
                            input bit poke);
        int n;
        n = (c == 0) ? 256 : int'(c);
        e_ptr0 = p; e_cnt0 = c; e_port0 = prt;
        @(negedge clk);
        ld_ptr = p; ld_cnt = c; ld_port = prt; start = 1'b1;
        @(negedge clk);
        start = 1'b0; ld_ptr = ~p; ld_cnt = c + 8'd7; ld_port = ~prt;
        check(busy && !done, "R1 start accepted, done cleared (R9)", {busy, done}, 2'b10);
        check(ptr_out == p && cnt_out == c, "R1 load", int'({ptr_out, cnt_out}), int'({p, c}));
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        check(n_wr == n, "R6 transfer count", n_wr, n);
        check(n_rd == n, "R2 read count", n_rd, n);
        check(n_err_rd == 0, "R2 read timing/address", bad_act, bad_exp);
        check(n_err_wr == 0, "R3/R4 write address, data, timing", bad_act, bad_exp);
        check(n_busy == 21 * (n - 1) + 16, "R7 busy length", n_busy, 21 * (n - 1) + 16);
        check(n_rpt == n && n_err_rpt == 0, "R8 repeat-point pulses", n_rpt, n);
        check(ptr_out == p - 16'(n), "R5 final pointer", int'(ptr_out), int'(p - 16'(n)));
        check(done && cnt_out == 0, "R9 done with zero counter", int'({done, cnt_out}), 9'h100);
        repeat (5) @(negedge clk);
        check(done && ptr_out == p - 16'(n) && !busy, "R9 values held after done",
              int'(ptr_out), int'(p - 16'(n)));
    endtask

    task automatic t_reset();
        check(!busy && !done && !mem_rd && !io_wr && !rpt_pulse, "R1 reset state",
              int'({busy, done, mem_rd, io_wr, rpt_pulse}), 0);
    endtask

    task automatic t_basic();     run_case(16'h1234, 8'd3, 8'h42, 1'b0); endtask
    task automatic t_single();    run_case(16'h8000, 8'd1, 8'hA5, 1'b0); endtask
    task automatic t_wrap_r5();   run_case(16'h0002, 8'd5, 8'h10, 1'b0); endtask
    task automatic t_full_r6();   run_case(16'h4000, 8'd0, 8'h77, 1'b0); endtask
    task automatic t_ignore_r10();
        run_case(16'hC0DE, 8'd4, 8'h3C, 1'b1);
        check(io_addr[7:0] == 8'h3C, "R10 port unchanged by busy start", int'(io_addr[7:0]), 8'h3C);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_single();
        t_wrap_r5();
        t_full_r6();
        t_ignore_r10();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule